// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block owns the two threshold values used by a synchronous FIFO's partial-fill flags: an almost-empty offset and an almost-full offset, each 14 bits wide for a 16K-entry buffer. Software or a board controller programs them through the same pins that normally move FIFO data. A load-select input decides, cycle by cycle, whether the write and read enables reach the FIFO storage or the offset registers instead.

Two loading methods exist: a 9-bit parallel port that fills one register half per clock, and a one-bit serial input that shifts the full 28-bit pair in one bit per clock. The method, and the default threshold value, are captured while master reset is asserted and then stay fixed until the next master reset. Both offsets can always be read back through the parallel output port. Both offset values go straight to the flag comparators outside the block. Write and read sides share one clock.

Top module: `fifo_offset_loader`

## Requirements
- R1: While master reset is held, both offsets take 0x07F if `ld_i` is 0 and 0x3FF if `ld_i` is 1. The write and read half pointers return to the almost-empty low half, and `q_o` returns to 0.
- R2: `ser_sel_i` is sampled only during master reset (1 = serial method, 0 = parallel method). Later changes to it have no effect until the next master reset.
- R3: In parallel method, with `ld_i`=0 and `wen_ni`=0, each clock writes one half, in the order almost-empty low, almost-empty high, almost-full low, almost-full high, then back to the first. A low half takes `d_i[8:0]` into offset bits 8:0. A high half takes `d_i[4:0]` into offset bits 13:9.
- R4: With `ld_i`=0 and `ren_ni`=0, each clock loads `q_o` with one half, in the same order and with the same wrap as R3, and the value appears after that clock edge. A high half appears on `q_o[4:0]` with `q_o[8:5]`=0. Otherwise `q_o` holds.
- R5: Parallel reads work the same way in serial method as in parallel method.
- R6: In serial method, with `ld_i`=0, `sen_ni`=0 and `wen_ni`=1, each clock shifts `si_i` in. After 28 such clocks, bit k of the stream (k=0 first) sits at almost-empty bit k for k<14, and at almost-full bit k-14 otherwise.
- R7: In serial method a parallel write (`wen_ni`=0) changes no offset and does not move the write pointer. In parallel method `sen_ni`/`si_i` change no offset.
- R8: With `ld_i`=1, `mem_we_o` = !`wen_ni` and `mem_re_o` = !`ren_ni`, and the offsets, pointers and `q_o` are unchanged. With `ld_i`=0 both memory strobes are 0.
- R9: With `ld_i`=0 and `wen_ni`, `ren_ni`, `sen_ni` all 1, nothing changes.
- R10: A parallel write and a parallel read in the same clock both take place. The read returns the half's value from before that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared write/read clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| ld_i | input | 1 | 1 = memory access, 0 = offset register access; also picks the reset default |
| ser_sel_i | input | 1 | Loading method choice, sampled during master reset |
| wen_ni | input | 1 | Write enable, active low |
| ren_ni | input | 1 | Read enable, active low |
| sen_ni | input | 1 | Serial shift enable, active low |
| si_i | input | 1 | Serial data bit |
| d_i | input | 9 | Parallel write data |
| q_o | output | 9 | Parallel read-back data |
| mem_we_o | output | 1 | Write strobe to FIFO storage |
| mem_re_o | output | 1 | Read strobe to FIFO storage |
| ae_ofs_o | output | 14 | Almost-empty offset to the flag comparator |
| af_ofs_o | output | 14 | Almost-full offset to the flag comparator |

## Verification
On every cycle the assertions check the following. The method flag never moves outside reset. The half pointers step by one exactly when an access of their kind is decoded. Offsets and `q_o` stay frozen during memory access and idle cycles. Each serial shift moves the chain by one bit, and high halves read back zero-padded. Only the bench's scenarios can show that the halves land in the right order with the right field widths, and that a full 28-bit serial load ends up bit-exact. They also show that defaults depend on `ld_i` at reset, and that a new master reset restores the defaults and switches the method.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

  // Register half order; the numeric order is the stepping order.
  typedef enum logic [1:0] {
    HALF_AE_LO = 2'd0,
    HALF_AE_HI = 2'd1,
    HALF_AF_LO = 2'd2,
    HALF_AF_HI = 2'd3
  } half_e;

  // Per-cycle access decision.
  typedef struct packed {
    logic mem_we;
    logic mem_re;
    logic reg_wr;
    logic reg_rd;
    logic reg_sh;
  } access_t;

  function automatic half_e next_half(half_e h);
    logic [1:0] nxt;
    nxt = h + 2'd1;
    return half_e'(nxt);
  endfunction

endpackage

// File: rtl/ofl_rst_sync.sv
module ofl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/ofl_access_dec.sv
module ofl_access_dec
  import ofl_pkg::*;
(
  input  logic    active_i,
  input  logic    ld_i,
  input  logic    wen_ni,
  input  logic    ren_ni,
  input  logic    sen_ni,
  input  logic    serial_i,
  output access_t acc_o
);

  always_comb begin
    acc_o = '0;
    if (active_i) begin
      if (ld_i) begin
        // R8: enables go to FIFO storage
        acc_o.mem_we = !wen_ni;
        acc_o.mem_re = !ren_ni;
      end else begin
        // R5: read-back in either method
        acc_o.reg_rd = !ren_ni;
        // R7: each method blocks the other one's loading path
        acc_o.reg_wr = !serial_i && !wen_ni;
        acc_o.reg_sh = serial_i && !sen_ni && wen_ni;
      end
    end
  end

endmodule

// File: rtl/ofl_offset_bank.sv
module ofl_offset_bank
  import ofl_pkg::*;
#(
  parameter int          OFS_W  = 14,
  parameter int          BUS_W  = 9,
  parameter logic [13:0] DEF_LO = 14'h007F,
  parameter logic [13:0] DEF_HI = 14'h03FF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             ser_sel_i,
  input  access_t          acc_i,
  input  logic             si_i,
  input  logic [BUS_W-1:0] d_i,
  output logic [OFS_W-1:0] ae_o,
  output logic [OFS_W-1:0] af_o,
  output logic             serial_o
);

  localparam int HI_W = OFS_W - BUS_W;

  logic             in_rst;
  logic [OFS_W-1:0] ae_q, ae_d;
  logic [OFS_W-1:0] af_q, af_d;
  logic             mode_q, mode_d;
  half_e            wptr_q, wptr_d;

  assign in_rst = !rst_ni;

  // Next state for offsets and method flag.
  always_comb begin
    ae_d   = ae_q;
    af_d   = af_q;
    mode_d = mode_q;
    if (in_rst) begin
      // R1, R2: defaults and method captured while reset is held
      ae_d   = ld_i ? DEF_HI : DEF_LO;
      af_d   = ld_i ? DEF_HI : DEF_LO;
      mode_d = ser_sel_i;
    end else if (acc_i.reg_wr) begin
      // R3: half selected by write pointer
      case (wptr_q)
        HALF_AE_LO: ae_d[BUS_W-1:0]     = d_i;
        HALF_AE_HI: ae_d[OFS_W-1:BUS_W] = d_i[HI_W-1:0];
        HALF_AF_LO: af_d[BUS_W-1:0]     = d_i;
        HALF_AF_HI: af_d[OFS_W-1:BUS_W] = d_i[HI_W-1:0];
        default:    ae_d                = ae_q;
      endcase
    end else if (acc_i.reg_sh) begin
      // R6: new bit enters at the top of the chain, oldest ends at bit 0
      {af_d, ae_d} = {si_i, af_q, ae_q[OFS_W-1:1]};
    end
  end

  always_comb begin
    wptr_d = next_half(wptr_q);
  end

  // Loaded during the reset window, so no asynchronous clear here.
  always_ff @(posedge clk_i) begin
    ae_q   <= ae_d;
    af_q   <= af_d;
    mode_q <= mode_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= HALF_AE_LO;
    end else if (acc_i.reg_wr) begin
      wptr_q <= wptr_d;
    end
  end

  assign ae_o     = ae_q;
  assign af_o     = af_q;
  assign serial_o = mode_q;

  assert_mode_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(mode_q));

  assert_wptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i.reg_wr |=> wptr_q == next_half($past(wptr_q)));

  assert_wptr_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |=> $stable(wptr_q));

  assert_shift_chain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i.reg_sh |=> (af_q[OFS_W-1] == $past(si_i)) &&
                     (ae_q[OFS_W-1] == $past(af_q[0])));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i.reg_wr || acc_i.reg_sh) |=> $stable(ae_q) && $stable(af_q));

endmodule

// File: rtl/ofl_read_port.sv
module ofl_read_port
  import ofl_pkg::*;
#(
  parameter int OFS_W = 14,
  parameter int BUS_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  access_t          acc_i,
  input  logic [OFS_W-1:0] ae_i,
  input  logic [OFS_W-1:0] af_i,
  output logic [BUS_W-1:0] q_o
);

  localparam int HI_W = OFS_W - BUS_W;

  half_e            rptr_q, rptr_d;
  logic [BUS_W-1:0] q_q, sel_val;

  // R4: high halves are zero-padded to the port width
  always_comb begin
    case (rptr_q)
      HALF_AE_LO: sel_val = ae_i[BUS_W-1:0];
      HALF_AE_HI: sel_val = BUS_W'(ae_i[OFS_W-1:BUS_W]);
      HALF_AF_LO: sel_val = af_i[BUS_W-1:0];
      HALF_AF_HI: sel_val = BUS_W'(af_i[OFS_W-1:BUS_W]);
      default:    sel_val = '0;
    endcase
    rptr_d = next_half(rptr_q);
  end

  // R10: register values sampled before any same-cycle write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= HALF_AE_LO;
      q_q    <= '0;
    end else if (acc_i.reg_rd) begin
      rptr_q <= rptr_d;
      q_q    <= sel_val;
    end
  end

  assign q_o = q_q;

  assert_rptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i.reg_rd |=> rptr_q == next_half($past(rptr_q)));

  assert_q_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i.reg_rd |=> $stable(q_o));

  assert_hi_pad_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i.reg_rd && rptr_q[0]) |=> q_o[BUS_W-1:HI_W] == '0);

endmodule

// File: rtl/fifo_offset_loader.sv
module fifo_offset_loader
  import ofl_pkg::*;
#(
  parameter int          OFS_W     = 14,
  parameter int          BUS_W     = 9,
  parameter int          RST_STAGES = 2,
  parameter logic [13:0] DEF_LO    = 14'h007F,
  parameter logic [13:0] DEF_HI    = 14'h03FF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             ser_sel_i,
  input  logic             wen_ni,
  input  logic             ren_ni,
  input  logic             sen_ni,
  input  logic             si_i,
  input  logic [BUS_W-1:0] d_i,
  output logic [BUS_W-1:0] q_o,
  output logic             mem_we_o,
  output logic             mem_re_o,
  output logic [OFS_W-1:0] ae_ofs_o,
  output logic [OFS_W-1:0] af_ofs_o
);

  logic    rst_sync_n;
  logic    serial_mode;
  access_t acc;

  ofl_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  ofl_access_dec u_dec (
    .active_i (rst_sync_n),
    .ld_i     (ld_i),
    .wen_ni   (wen_ni),
    .ren_ni   (ren_ni),
    .sen_ni   (sen_ni),
    .serial_i (serial_mode),
    .acc_o    (acc)
  );

  ofl_offset_bank #(
    .OFS_W  (OFS_W),
    .BUS_W  (BUS_W),
    .DEF_LO (DEF_LO),
    .DEF_HI (DEF_HI)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .ld_i      (ld_i),
    .ser_sel_i (ser_sel_i),
    .acc_i     (acc),
    .si_i      (si_i),
    .d_i       (d_i),
    .ae_o      (ae_ofs_o),
    .af_o      (af_ofs_o),
    .serial_o  (serial_mode)
  );

  ofl_read_port #(
    .OFS_W (OFS_W),
    .BUS_W (BUS_W)
  ) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .acc_i  (acc),
    .ae_i   (ae_ofs_o),
    .af_i   (af_ofs_o),
    .q_o    (q_o)
  );

  assign mem_we_o = acc.mem_we;
  assign mem_re_o = acc.mem_re;

  assert_ld_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ld_i |=> $stable(ae_ofs_o) && $stable(af_ofs_o) && $stable(q_o));

endmodule

// File: tb/test_fifo_offset_loader.sv
`timescale 1ns/1ps
module test_fifo_offset_loader;

  localparam real CYC = 4.0;

  logic       clk = 1'b0;
  logic       rst_n, ld, ser_sel, wen_n, ren_n, sen_n, si;
  logic [8:0] d;
  logic [8:0] q;
  logic       mem_we, mem_re;
  logic [13:0] ae, af;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // Behavioural reference
  logic [13:0] m_ae, m_af;
  int          m_wp, m_rp;
  logic [8:0]  m_q;
  bit          m_ser;

  always #(CYC/2) clk = ~clk;

  fifo_offset_loader i_fifo_offset_loader (
    .clk_i(clk), .rst_ni(rst_n), .ld_i(ld), .ser_sel_i(ser_sel),
    .wen_ni(wen_n), .ren_ni(ren_n), .sen_ni(sen_n), .si_i(si), .d_i(d),
    .q_o(q), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .ae_ofs_o(ae), .af_ofs_o(af)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] m_half(int idx);
    case (idx)
      0: return m_ae[8:0];
      1: return {4'b0, m_ae[13:9]};
      2: return m_af[8:0];
      default: return {4'b0, m_af[13:9]};
    endcase
  endfunction

  task automatic cmp_state(string req);
    chk(req, "ae_ofs", 32'(ae), 32'(m_ae));
    chk(req, "af_ofs", 32'(af), 32'(m_af));
    chk(req, "q", 32'(q), 32'(m_q));
  endtask

  // One clock with the given inputs; called at a falling edge.
  task automatic step(string req, logic l, logic wn, logic rn, logic sn, logic s, logic [8:0] dv);
    logic [27:0] chain;
    ld = l; wen_n = wn; ren_n = rn; sen_n = sn; si = s; d = dv;
    #1;
    chk(req, "mem_we", 32'(mem_we), 32'(l & !wn));
    chk(req, "mem_re", 32'(mem_re), 32'(l & !rn));
    @(posedge clk);
    if (!l) begin
      if (!rn) begin
        m_q  = m_half(m_rp);
        m_rp = (m_rp + 1) % 4;
      end
      if (!m_ser && !wn) begin
        case (m_wp)
          0: m_ae[8:0]  = dv;
          1: m_ae[13:9] = dv[4:0];
          2: m_af[8:0]  = dv;
          default: m_af[13:9] = dv[4:0];
        endcase
        m_wp = (m_wp + 1) % 4;
      end else if (m_ser && !sn && wn) begin
        chain = {m_af, m_ae};
        chain = {s, chain[27:1]};
        m_af = chain[27:14];
        m_ae = chain[13:0];
      end
    end
    @(negedge clk);
    cmp_state(req);
  endtask

  task automatic idle(string req);
    step(req, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000);
  endtask

  task automatic do_reset(logic l, logic s);
    @(negedge clk);
    ld = l; ser_sel = s; wen_n = 1; ren_n = 1; sen_n = 1; si = 0; d = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    m_ae = l ? 14'h03FF : 14'h007F;
    m_af = m_ae;
    m_wp = 0; m_rp = 0; m_q = '0; m_ser = s;
    cmp_state("R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [27:0] pat;
    rst_n = 1; ld = 0; ser_sel = 0; wen_n = 1; ren_n = 1; sen_n = 1; si = 0; d = '0;

    // ---- Parallel method, low default ----
    do_reset(1'b0, 1'b0);
    // R8: memory access leaves offsets alone
    step("R8", 1, 0, 0, 1, 0, 9'h1AA);
    step("R8", 1, 1, 0, 0, 1, 9'h155);
    step("R8", 1, 0, 1, 1, 0, 9'h0FF);
    // R3: four halves in order, then wrap
    step("R3", 0, 0, 1, 1, 0, 9'h1A5);
    step("R3", 0, 0, 1, 1, 0, 9'h1F3);
    step("R3", 0, 0, 1, 1, 0, 9'h0F0);
    step("R3", 0, 0, 1, 1, 0, 9'h1FF);
    chk("R3", "ae after 4 writes", 32'(ae), 32'({5'h13, 9'h1A5}));
    chk("R3", "af after 4 writes", 32'(af), 32'({5'h1F, 9'h0F0}));
    step("R3", 0, 0, 1, 1, 0, 9'h055);
    chk("R3", "wrap to ae low", 32'(ae[8:0]), 32'h055);
    // R4: read back in order, with padding and wrap
    step("R4", 0, 1, 0, 1, 0, 9'h000);
    chk("R4", "read ae low", 32'(q), 32'h055);
    step("R4", 0, 1, 0, 1, 0, 9'h000);
    chk("R4", "read ae high", 32'(q), 32'h013);
    step("R4", 0, 1, 0, 1, 0, 9'h000);
    step("R4", 0, 1, 0, 1, 0, 9'h000);
    chk("R4", "read af high", 32'(q), 32'h01F);
    step("R4", 0, 1, 0, 1, 0, 9'h000);
    chk("R4", "read wraps", 32'(q), 32'h055);
    // R7: serial input ignored in parallel method
    for (int i = 0; i < 6; i++) step("R7", 0, 1, 1, 0, 1'(i), 9'h000);
    // R9: idle
    for (int i = 0; i < 4; i++) idle("R9");
    // R10: write and read together (both pointers at ae high)
    step("R10", 0, 0, 0, 1, 0, 9'h00A);
    chk("R10", "read sees old value", 32'(q), 32'h013);
    chk("R10", "write landed", 32'(ae[13:9]), 32'h0A);

    // ---- Serial method, high default ----
    do_reset(1'b1, 1'b1);
    // R7: parallel writes ignored, also with sen low
    step("R7", 0, 0, 1, 1, 0, 9'h000);
    step("R7", 0, 0, 1, 0, 1, 9'h000);
    step("R7", 0, 0, 1, 1, 0, 9'h000);
    // R6: full 28-bit serial load
    pat = 28'hA5C3E71;
    for (int i = 0; i < 28; i++) step("R6", 0, 1, 1, 0, pat[i], 9'h000);
    chk("R6", "ae serial", 32'(ae), 32'(pat[13:0]));
    chk("R6", "af serial", 32'(af), 32'(pat[27:14]));
    // R5: read-back in serial method
    for (int i = 0; i < 4; i++) step("R5", 0, 1, 0, 1, 0, 9'h000);
    chk("R5", "read af high serial", 32'(q), 32'(pat[27:23]));
    // R2: method fixed after reset
    ser_sel = 0;
    step("R2", 0, 0, 1, 1, 0, 9'h111);
    step("R2", 0, 1, 1, 0, 1, 9'h000);
    chk("R2", "serial still active", 32'(af[13]), 32'h1);
    // R8 in serial method
    step("R8", 1, 1, 0, 0, 0, 9'h000);

    // ---- Back to parallel, low default ----
    do_reset(1'b0, 1'b0);
    chk("R1", "ae default restored", 32'(ae), 32'h07F);
    step("R2", 0, 0, 1, 1, 0, 9'h123);
    chk("R2", "parallel after re-reset", 32'(ae[8:0]), 32'h123);
    step("R1", 0, 1, 0, 1, 0, 9'h000);
    chk("R1", "read pointer reset", 32'(q), 32'h123);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule